// File: doc/BRIEF.md
# NAND Flash Page Program Sequencer

This block runs one complete page program operation on a raw NAND flash device. The host pulses a start request with a 16-bit column address and a 24-bit row address, then streams the page data over a valid/ready input. The block drives the chip select, command latch, address latch, write strobe, read strobe, write-protect line and data bus in a fixed order. That order is: setup command, five address bytes, the page data, confirm command, wait for the device to become ready, status command, and one status read. It ends with a one-cycle done pulse and a status byte. The pass/fail flag is bit 0 of that status byte.

Strobe timing is expressed in clock cycles. Every write or read strobe stays low for `LOW_CYC` clocks and high for at least `HIGH_CYC` clocks. The data bus is `DW` bits wide (8 or 16). Command and address bytes use the low 8 lines, and the upper lines carry zero. If the device never returns ready within `TIMEOUT_CYC` clocks, the operation ends with a timeout flag.

The controller is a state machine with these states: `ST_IDLE`, `ST_CMD_PROG`, `ST_ADDR`, `ST_DATA`, `ST_CMD_CONF`, `ST_WAIT_RDY`, `ST_CMD_STAT`, `ST_READ_STAT` and `ST_FINISH`. Its transitions are:
- IDLE→CMD_PROG on start.
- CMD_PROG→ADDR when the strobe finishes.
- ADDR→DATA after the fifth address strobe.
- DATA→CMD_CONF after the last data strobe.
- CMD_CONF→WAIT_RDY when the strobe finishes.
- WAIT_RDY→CMD_STAT on a rising ready edge, or WAIT_RDY→FINISH on timeout.
- CMD_STAT→READ_STAT when the strobe finishes.
- READ_STAT→FINISH when the read strobe finishes.
- FINISH→IDLE unconditionally.

Top module: `nand_page_programmer`

## Requirements
- R1: After reset the block is idle: `flash_cs_n`=1, `flash_wr_n`=1, `flash_rd_n`=1, `flash_cmd_latch`=0, `flash_addr_latch`=0, `busy_o`=0, `done_o`=0 and `flash_wprot_n`=0 (protection asserted while idle).
- R2: A command cycle has `flash_cmd_latch`=1 and `flash_addr_latch`=0, with the command code on data bits [7:0] and exactly one write strobe. The operation issues 0x80 first, then 0x10 after the data, then 0x70 after ready returns. The two latch lines are never high together.
- R3: Five address cycles follow 0x80, each with `flash_addr_latch`=1, `flash_cmd_latch`=0 and one write strobe. Their bytes are, in order: column[7:0], column[15:8], row[7:0], row[15:8], row[23:16].
- R4: Exactly `PAGE_BEATS` data cycles follow the address. Each has both latch lines low and one write strobe, and carries the accepted beats in arrival order. A beat is accepted only in a cycle where `wr_valid_i` and `wr_ready_o` are both high, and gaps in `wr_valid_i` only delay the sequence.
- R5: Every write or read strobe is low for exactly `LOW_CYC` clocks. It is high for at least `HIGH_CYC` clocks before the next strobe of the same operation.
- R6: `flash_cs_n` goes low before the first command and stays low without a break until the status read strobe has ended. No strobe is ever low while `flash_cs_n` is high.
- R7: `flash_wprot_n` is 1 in every cycle in which `busy_o` is 1.
- R8: After the confirm command, the status command 0x70 is not issued until `flash_ready` has gone low and then high again.
- R9: The status byte is read with a single read strobe while `flash_dq_oe`=0. It appears on `status_o`, and `fail_o` equals its bit 0.
- R10: If `flash_ready` does not rise within `TIMEOUT_CYC` clocks of entering the busy wait, the operation ends with `timeout_o`=1 and `status_o`=0, and no status command is sent.
- R11: A start request while `busy_o`=1 is ignored. It changes neither the bytes sent nor the number of cycles, and it starts no second operation.
- R12: `done_o` is a single-cycle pulse at the end of each operation. `status_o`, `fail_o` and `timeout_o` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| col_addr_i | input | 16 | Column address of the operation |
| row_addr_i | input | 24 | Row (page) address of the operation |
| wr_data_i | input | DW | Page data beat |
| wr_valid_i | input | 1 | Page data beat valid |
| wr_ready_o | output | 1 | Page data beat taken this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| status_o | output | 8 | Status byte read from the device |
| fail_o | output | 1 | Program failed (status bit 0) |
| timeout_o | output | 1 | Ready never returned |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_cmd_latch | output | 1 | Command latch enable, active high |
| flash_addr_latch | output | 1 | Address latch enable, active high |
| flash_wr_n | output | 1 | Write strobe, active low |
| flash_rd_n | output | 1 | Read strobe, active low |
| flash_wprot_n | output | 1 | Write protect, active low |
| flash_ready | input | 1 | Device ready (1) / busy (0), asynchronous |
| flash_dq_o | output | DW | Data bus output value |
| flash_dq_oe | output | 1 | Data bus output enable |
| flash_dq_i | input | DW | Data bus input value |

## Verification
The bench stalls the data stream between beats. A sequencer that accepted a beat without a valid would send a wrong byte or the wrong number of data cycles. It holds the device busy for a while and then forever. A design that polled ready as a level, and not as an edge, would send 0x70 before the rise, and a design without the watchdog would hang. It also pulses start in the middle of an operation, which would corrupt the address bytes or start a second operation if it were not ignored. Throughout the run it measures every strobe width and watches chip select, so a strobe that is one clock short or a chip-select gap between cycles shows up.

// File: rtl/nps_pkg.sv
package nps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD_PROG,
        ST_ADDR,
        ST_DATA,
        ST_CMD_CONF,
        ST_WAIT_RDY,
        ST_CMD_STAT,
        ST_READ_STAT,
        ST_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } strobe_phase_t;

    localparam logic [7:0] OP_PROG_SETUP   = 8'h80;
    localparam logic [7:0] OP_PROG_CONFIRM = 8'h10;
    localparam logic [7:0] OP_READ_STATUS  = 8'h70;

    localparam int COL_W      = 16;
    localparam int ROW_W      = 24;
    localparam int ADDR_BYTES = (COL_W + ROW_W) / 8;

endpackage

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic idle_o,
    output logic low_o,
    output logic sample_o,
    output logic done_o
);
    import nps_pkg::*;

    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
    localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);

    strobe_phase_t phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (go_i) begin
                        phase_q <= PH_LOW;
                        cnt_q   <= LOW_LAST;
                    end
                end
                PH_LOW: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_HIGH;
                        cnt_q   <= HIGH_LAST;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        idle_o   = (phase_q == PH_IDLE);
        low_o    = (phase_q == PH_LOW);
        sample_o = (phase_q == PH_LOW)  && (cnt_q == '0);
        done_o   = (phase_q == PH_HIGH) && (cnt_q == '0);
    end

    // R5
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |-> idle_o);

    // R5
    low_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_o |-> (cnt_q <= LOW_LAST));

    // R5
    high_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |=> (phase_q == PH_HIGH));

endmodule

// File: rtl/nps_addr_sel.sv
module nps_addr_sel #(
    parameter int COL_W = 16,
    parameter int ROW_W = 24
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [2:0]       idx_i,
    output logic [7:0]       byte_o
);
    localparam int NB = (COL_W + ROW_W) / 8;

    logic [COL_W+ROW_W-1:0] addr_all;
    logic [7:0]             bytes [NB];

    assign addr_all = {row_i, col_i};

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign bytes[g] = addr_all[g*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        for (int i = 0; i < NB; i++) begin
            if (idx_i == 3'(i)) byte_o = bytes[i];
        end
    end

    // R3
    idx_range_chk: assert final (32'(idx_i) < NB);

endmodule

// File: rtl/nps_rdy_wait.sv
module nps_rdy_wait #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic rdy_async_i,
    output logic rise_o,
    output logic expired_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

    logic          sync1_q, sync2_q, prev_q;
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= rdy_async_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm_i) begin
            cnt_q <= '0;
        end else if (cnt_q != T_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        rise_o    = arm_i && sync2_q && !prev_q;
        expired_o = arm_i && (cnt_q == T_LAST) && !rise_o;
    end

    // R10
    wait_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= T_LAST);

    // R8
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !prev_q);

endmodule

// File: rtl/nand_page_programmer.sv
module nand_page_programmer #(
    parameter int DW          = 8,
    parameter int PAGE_BEATS  = 8,
    parameter int LOW_CYC     = 2,
    parameter int HIGH_CYC    = 2,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [15:0]   col_addr_i,
    input  logic [23:0]   row_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          wr_valid_i,
    output logic          wr_ready_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [7:0]    status_o,
    output logic          fail_o,
    output logic          timeout_o,
    output logic          flash_cs_n,
    output logic          flash_cmd_latch,
    output logic          flash_addr_latch,
    output logic          flash_wr_n,
    output logic          flash_rd_n,
    output logic          flash_wprot_n,
    input  logic          flash_ready,
    output logic [DW-1:0] flash_dq_o,
    output logic          flash_dq_oe,
    input  logic [DW-1:0] flash_dq_i
);
    import nps_pkg::*;

    localparam int BW = (PAGE_BEATS > 1) ? $clog2(PAGE_BEATS) : 1;
    localparam logic [BW-1:0] BEAT_LAST = BW'(PAGE_BEATS - 1);
    localparam logic [2:0]    ADDR_LAST = 3'(ADDR_BYTES - 1);

    seq_state_t    state_q, state_d;
    logic [2:0]    idx_q;
    logic [BW-1:0] beat_q;
    logic [15:0]   col_q;
    logic [23:0]   row_q;
    logic [DW-1:0] dq_q;
    logic [7:0]    status_q;
    logic          tmo_q;

    logic stb_go, stb_idle, stb_low, stb_sample, stb_done;
    logic rdy_rise, rdy_expired;
    logic issue, launch;
    logic [7:0] addr_byte;

    nps_strobe #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (stb_go),
        .idle_o   (stb_idle),
        .low_o    (stb_low),
        .sample_o (stb_sample),
        .done_o   (stb_done)
    );

    nps_rdy_wait #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rdy (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (state_q == ST_WAIT_RDY),
        .rdy_async_i (flash_ready),
        .rise_o      (rdy_rise),
        .expired_o   (rdy_expired)
    );

    nps_addr_sel #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .col_i  (col_q),
        .row_i  (row_q),
        .idx_i  (idx_q),
        .byte_o (addr_byte)
    );

    if (DW > 8) begin : g_wide
        logic unused_dq_hi;
        assign unused_dq_hi = ^flash_dq_i[DW-1:8];
    end

    always_comb begin
        issue = (state_q == ST_CMD_PROG) || (state_q == ST_ADDR) ||
                (state_q == ST_DATA)     || (state_q == ST_CMD_CONF) ||
                (state_q == ST_CMD_STAT) || (state_q == ST_READ_STAT);
        launch = issue && stb_idle && ((state_q != ST_DATA) || wr_valid_i);
        stb_go = launch;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_CMD_PROG;
            ST_CMD_PROG:  if (stb_done) state_d = ST_ADDR;
            ST_ADDR:      if (stb_done && idx_q == ADDR_LAST) state_d = ST_DATA;
            ST_DATA:      if (stb_done && beat_q == BEAT_LAST) state_d = ST_CMD_CONF;
            ST_CMD_CONF:  if (stb_done) state_d = ST_WAIT_RDY;
            ST_WAIT_RDY: begin
                if (rdy_rise)         state_d = ST_CMD_STAT;
                else if (rdy_expired) state_d = ST_FINISH;
            end
            ST_CMD_STAT:  if (stb_done) state_d = ST_READ_STAT;
            ST_READ_STAT: if (stb_done) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            beat_q   <= '0;
            col_q    <= '0;
            row_q    <= '0;
            dq_q     <= '0;
            status_q <= '0;
            tmo_q    <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                col_q    <= col_addr_i;
                row_q    <= row_addr_i;
                idx_q    <= '0;
                beat_q   <= '0;
                status_q <= '0;
                tmo_q    <= 1'b0;
            end
            if (launch) begin
                unique case (state_q)
                    ST_CMD_PROG: dq_q <= DW'(OP_PROG_SETUP);
                    ST_ADDR:     dq_q <= DW'(addr_byte);
                    ST_DATA:     dq_q <= wr_data_i;
                    ST_CMD_CONF: dq_q <= DW'(OP_PROG_CONFIRM);
                    ST_CMD_STAT: dq_q <= DW'(OP_READ_STATUS);
                    default:     dq_q <= '0;
                endcase
            end
            if (stb_done && state_q == ST_ADDR && idx_q != ADDR_LAST)
                idx_q <= idx_q + 1'b1;
            if (stb_done && state_q == ST_DATA && beat_q != BEAT_LAST)
                beat_q <= beat_q + 1'b1;
            if (stb_sample && state_q == ST_READ_STAT)
                status_q <= flash_dq_i[7:0];
            if (state_q == ST_WAIT_RDY && rdy_expired)
                tmo_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o           = (state_q != ST_IDLE);
        done_o           = (state_q == ST_FINISH);
        flash_cs_n       = (state_q == ST_IDLE) || (state_q == ST_FINISH);
        flash_cmd_latch  = (state_q == ST_CMD_PROG) || (state_q == ST_CMD_CONF) ||
                           (state_q == ST_CMD_STAT);
        flash_addr_latch = (state_q == ST_ADDR);
        flash_wr_n       = !(stb_low && state_q != ST_READ_STAT);
        flash_rd_n       = !(stb_low && state_q == ST_READ_STAT);
        flash_dq_oe      = issue && (state_q != ST_READ_STAT);
        flash_dq_o       = dq_q;
        flash_wprot_n    = (state_q != ST_IDLE);
        wr_ready_o       = launch && (state_q == ST_DATA);
        status_o         = status_q;
        fail_o           = status_q[0];
        timeout_o        = tmo_q;
    end

    // R2
    latch_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_cmd_latch && flash_addr_latch));

    // R6
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_wr_n || !flash_rd_n) |-> !flash_cs_n);

    // R7
    wprot_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> flash_wprot_n);

    // R9
    read_bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_rd_n |-> !flash_dq_oe);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(col_q) && $stable(row_q)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> wr_valid_i);

endmodule

// File: tb/nand_page_programmer_tb.sv
`timescale 1ns/1ps
module nand_page_programmer_tb;
    localparam int DW = 8;
    localparam int PB = 6;
    localparam int LOWC = 2;
    localparam int HIGHC = 3;
    localparam int TMO = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [15:0] col_i = '0;
    logic [23:0] row_i = '0;
    logic [DW-1:0] wdata = '0;
    logic wvalid = 1'b0;
    logic wready, busy, done, fail, tmo;
    logic [7:0] status;
    logic cs_n, cle, ale, wr_n, rd_n, wp_n, oe;
    logic rdy = 1'b1;
    logic [DW-1:0] dq_o, dq_i;
    logic [7:0] status_val = 8'h00;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    nand_page_programmer #(.DW(DW), .PAGE_BEATS(PB), .LOW_CYC(LOWC),
                           .HIGH_CYC(HIGHC), .TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .col_addr_i(col_i), .row_addr_i(row_i),
        .wr_data_i(wdata), .wr_valid_i(wvalid), .wr_ready_o(wready),
        .busy_o(busy), .done_o(done), .status_o(status), .fail_o(fail),
        .timeout_o(tmo), .flash_cs_n(cs_n), .flash_cmd_latch(cle),
        .flash_addr_latch(ale), .flash_wr_n(wr_n), .flash_rd_n(rd_n),
        .flash_wprot_n(wp_n), .flash_ready(rdy), .flash_dq_o(dq_o),
        .flash_dq_oe(oe), .flash_dq_i(dq_i)
    );

    assign dq_i = (!rd_n) ? status_val : '0;

    // flash model and monitors
    logic       log_cle [64];
    logic       log_ale [64];
    logic [7:0] log_dq  [64];
    int         log_cyc [64];
    int log_n = 0;
    int rd_pulses = 0;
    int cs_rises = 0;
    int width_err = 0;
    int cs_err = 0;
    int wp_err = 0;
    int busy_len = 20;
    int busy_left = 0;
    int rdy_rise_cyc = -1;
    int cyc = 0;
    int lowrun = 0;
    int highrun = 0;
    bit seen_rise = 1'b0;
    logic prev_stb = 1'b1;
    logic prev_cs = 1'b1;
    logic prev_wr = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (busy && !wp_n) wp_err++;
            if ((!wr_n || !rd_n) && cs_n) cs_err++;
            if (!prev_cs && cs_n) begin
                cs_rises++;
                seen_rise = 1'b0;
            end
            if (!(wr_n && rd_n)) begin
                if (prev_stb) begin
                    if (seen_rise && highrun < HIGHC) width_err++;
                    lowrun = 0;
                end
                lowrun++;
            end else begin
                if (!prev_stb) begin
                    if (lowrun != LOWC) width_err++;
                    seen_rise = 1'b1;
                    highrun = 0;
                end
                highrun++;
            end
            if (!prev_wr && wr_n && log_n < 64) begin
                log_cle[log_n] = cle;
                log_ale[log_n] = ale;
                log_dq[log_n]  = dq_o[7:0];
                log_cyc[log_n] = cyc;
                log_n++;
                if (cle && dq_o[7:0] == 8'h10) begin
                    rdy = 1'b0;
                    busy_left = busy_len;
                end
            end
            if (!(prev_stb) && wr_n && rd_n && !prev_wr_was_wr) rd_pulses++;
            if (!rdy && busy_left > 0) begin
                busy_left--;
                if (busy_left == 0) begin
                    rdy = 1'b1;
                    rdy_rise_cyc = cyc;
                end
            end
        end
        prev_stb = wr_n && rd_n;
        prev_wr_was_wr = !wr_n;
        prev_cs = cs_n;
        prev_wr = wr_n;
    end
    logic prev_wr_was_wr = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input logic [7:0] base, input int i);
        return base + 8'(i * 17);
    endfunction

    logic [7:0] r_status;
    logic r_fail, r_tmo;
    bit r_done;

    task automatic feed(input logic [7:0] base, input int gap);
        for (int i = 0; i < PB; i++) begin
            @(negedge clk);
            wvalid = 1'b1;
            wdata  = dbyte(base, i);
            #1;
            while (!wready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
            @(negedge clk);
            wvalid = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [15:0] col, input logic [23:0] row,
                          input logic [7:0] base, input int gap, input int blen,
                          input logic [7:0] sval, input bit intrude);
        log_n = 0;
        rd_pulses = 0;
        cs_rises = 0;
        rdy_rise_cyc = -1;
        busy_len = blen;
        status_val = sval;
        r_done = 1'b0;
        @(negedge clk);
        col_i = col;
        row_i = row;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        fork
            feed(base, gap);
            begin
                if (intrude) begin
                    repeat (25) @(negedge clk);
                    col_i = 16'hFFFF;
                    row_i = 24'hEEEEEE;
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
        join
        for (int k = 0; k < 3000 && !r_done; k++) begin
            @(negedge clk);
            if (done) begin
                r_done = 1'b1;
                r_status = status;
                r_fail = fail;
                r_tmo = tmo;
            end
        end
        chk(r_done, "R12 done pulse seen", 32'(r_done), 1);
        @(negedge clk);
        chk(!done, "R12 done single cycle", 32'(done), 0);
        rdy = 1'b1;
    endtask

    task automatic check_sequence(input logic [15:0] col, input logic [23:0] row,
                                  input logic [7:0] base, input bit with_stat,
                                  input string tag);
        logic [39:0] a;
        int n;
        bit ok;
        a = {row, col};
        n = with_stat ? PB + 8 : PB + 7;
        chk(log_n == n, {tag, " R2 write strobe count"}, 32'(log_n), 32'(n));
        chk(log_cle[0] && !log_ale[0] && log_dq[0] == 8'h80, {tag, " R2 setup cmd"},
            32'(log_dq[0]), 32'h80);
        ok = 1'b1;
        for (int i = 0; i < 5; i++)
            if (!log_ale[1+i] || log_cle[1+i] || log_dq[1+i] != a[i*8 +: 8]) ok = 1'b0;
        chk(ok, {tag, " R3 address bytes"}, 32'(log_dq[1]), 32'(a[7:0]));
        ok = 1'b1;
        for (int i = 0; i < PB; i++)
            if (log_ale[6+i] || log_cle[6+i] || log_dq[6+i] != dbyte(base, i)) ok = 1'b0;
        chk(ok, {tag, " R4 data beats"}, 32'(log_dq[6]), 32'(dbyte(base, 0)));
        chk(log_cle[PB+6] && log_dq[PB+6] == 8'h10, {tag, " R2 confirm cmd"},
            32'(log_dq[PB+6]), 32'h10);
        if (with_stat) begin
            chk(log_cle[PB+7] && log_dq[PB+7] == 8'h70, {tag, " R2 status cmd"},
                32'(log_dq[PB+7]), 32'h70);
            chk(rdy_rise_cyc >= 0 && log_cyc[PB+7] > rdy_rise_cyc,
                {tag, " R8 status after ready rise"}, 32'(log_cyc[PB+7]),
                32'(rdy_rise_cyc));
            chk(rd_pulses == 1, {tag, " R9 one read strobe"}, 32'(rd_pulses), 1);
        end
        chk(cs_rises == 1, {tag, " R6 chip select unbroken"}, 32'(cs_rises), 1);
    endtask

    task automatic t_reset();
        chk(cs_n && wr_n && rd_n && !cle && !ale, "R1 bus idle after reset",
            {27'd0, cs_n, wr_n, rd_n, cle, ale}, 32'b11100);
        chk(!busy && !done && !wp_n, "R1 busy/done/wprot after reset",
            {29'd0, busy, done, wp_n}, 0);
    endtask

    task automatic t_basic();
        run_op(16'h0123, 24'h456789, 8'h10, 0, 20, 8'hC0, 1'b0);
        check_sequence(16'h0123, 24'h456789, 8'h10, 1'b1, "basic");
        chk(r_status == 8'hC0 && !r_fail && !r_tmo, "R9 status pass",
            32'(r_status), 32'hC0);
    endtask

    task automatic t_fail_stall();
        run_op(16'hA5F0, 24'h0F1E2D, 8'h33, 3, 35, 8'hC1, 1'b0);
        check_sequence(16'hA5F0, 24'h0F1E2D, 8'h33, 1'b1, "stall");
        chk(r_fail && r_status == 8'hC1, "R9 fail flag from bit 0",
            32'(r_fail), 1);
        repeat (5) @(negedge clk);
        chk(status == 8'hC1 && fail && !tmo, "R12 results held", 32'(status), 32'hC1);
    endtask

    task automatic t_timeout();
        run_op(16'h0007, 24'h000100, 8'h5A, 0, 0, 8'hC0, 1'b0);
        check_sequence(16'h0007, 24'h000100, 8'h5A, 1'b0, "timeout");
        chk(r_tmo && r_status == 8'h00, "R10 timeout flag", 32'(r_tmo), 1);
        chk(rd_pulses == 0, "R10 no status read", 32'(rd_pulses), 0);
    endtask

    task automatic t_intrude();
        int n0;
        run_op(16'h1357, 24'h2468AC, 8'h77, 2, 20, 8'hE0, 1'b1);
        check_sequence(16'h1357, 24'h2468AC, 8'h77, 1'b1, "R11 intrude");
        n0 = log_n;
        repeat (40) @(negedge clk);
        chk(!busy && log_n == n0, "R11 no second operation", 32'(log_n), 32'(n0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fail_stall();
        t_timeout();
        t_intrude();
        chk(width_err == 0, "R5 strobe widths", 32'(width_err), 0);
        chk(cs_err == 0, "R6 no strobe without chip select", 32'(cs_err), 0);
        chk(wp_err == 0, "R7 write protect released while busy", 32'(wp_err), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        tests++;
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule